// File: doc/BRIEF.md
# Ring all-reduce engine

A synchronous model of `NODES` processing nodes joined in a one-directional ring that together compute an element-wise integer sum across all of their local vectors. Each node stores a vector of `NODES * CHUNK_LEN` elements, viewed as `NODES` equal chunks. After a start pulse the nodes run two ring phases in lockstep. In the first phase, partial sums travel around the ring and are added into the receiver's copy. In the second phase, the fully reduced chunks circulate and overwrite the stale copies. A done pulse then marks the point at which every node holds the complete sum.

Each node forwards only to node `(i+1) mod NODES` through one registered link. A chunk crosses a link one element per clock. A step ends with one drain cycle, in which the last element lands before the next step reads it. Vectors are loaded and inspected through an indexed write port and a combinational read port. Element `j` of a node's vector belongs to chunk `j / CHUNK_LEN` at offset `j mod CHUNK_LEN`. Addition wraps modulo 2^`DATA_W`.

Top module: `ring_allreduce`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and every element of every node reads zero.
- R2: While idle, a write with `wr_en_i` high stores `wr_data_i` at element `wr_addr_i` of node `wr_node_i`. Element j lies in chunk j/CHUNK_LEN. From the next cycle it reads back on `rd_data_o` when `rd_node_i`/`rd_addr_i` select it.
- R3: Writes presented while `busy_o` is high are ignored and leave all node contents unaffected.
- R4: A start pulse sampled while idle raises `busy_o` in the following cycle.
- R5: `busy_o` stays high for exactly 2(NODES-1)(CHUNK_LEN+1) cycles. `done_o` rises in the cycle right after `busy_o` falls, and it is never high together with `busy_o`.
- R6: `done_o` is high for exactly one cycle per operation.
- R7: From the done cycle onward, element j of every node equals the sum of element j of all nodes as they stood at start.
- R8: A start pulse sampled while `busy_o` is high is ignored. This holds even in the final cycle of the operation: timing and result are unchanged, and the block is idle after done.
- R9: Once the first phase has ended (after (NODES-1)(CHUNK_LEN+1) busy cycles), node i already holds the complete sum in chunk (i+1) mod NODES, while the operation is still busy.
- R10: Sums wrap modulo 2^DATA_W; with every element 0xFFFF and four nodes each result is 0xFFFC.
- R11: A start pulse sampled in the done cycle is accepted and begins a new operation on the reduced vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| wr_en_i | input | 1 | Element write enable (idle only) |
| wr_node_i | input | $clog2(NODES) | Node selected for write |
| wr_addr_i | input | $clog2(NODES*CHUNK_LEN) | Element index for write |
| wr_data_i | input | DATA_W | Write data |
| rd_node_i | input | $clog2(NODES) | Node selected for read |
| rd_addr_i | input | $clog2(NODES*CHUNK_LEN) | Element index for read |
| rd_data_o | output | DATA_W | Combinational read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two things can meet in one cycle: the final step's drain, which ends the operation and arms done, and a new start pulse. A start driven into the last busy cycle must be dropped, leaving done at its fixed cycle and the block idle afterwards. A start driven into the done cycle itself must be accepted. The bench provokes both cases in separate runs. It judges each by the cycle in which busy and done change and by the reduced contents read back afterwards. It also drives a write during the second phase into a chunk that phase never overwrites, so that a leaked write would show up in the final sums.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic {
    PH_REDUCE = 1'b0,
    PH_GATHER = 1'b1
  } ar_phase_e;
endpackage

// File: rtl/ar_seq.sv
module ar_seq
  import ar_pkg::*;
#(
  parameter int NODES     = 4,
  parameter int CHUNK_LEN = 2,
  localparam int STEPS    = 2 * (NODES - 1),
  localparam int SW       = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int EW       = $clog2(CHUNK_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          send_o,
  output ar_phase_e     phase_o,
  output logic [SW-1:0] step_o,
  output logic [EW-1:0] elem_o
);

  logic          busy_q, done_q;
  logic [SW-1:0] step_q;
  logic [EW-1:0] elem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      elem_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
          elem_q <= '0;
        end
      end else if (elem_q == EW'(CHUNK_LEN)) begin
        // drain cycle: last element of the chunk has landed
        elem_q <= '0;
        if (step_q == SW'(STEPS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else begin
        elem_q <= elem_q + 1'b1;
      end
    end
  end

  always_comb begin
    phase_o = (step_q >= SW'(NODES - 1)) ? PH_GATHER : PH_REDUCE;
    step_o  = (phase_o == PH_GATHER) ? step_q - SW'(NODES - 1) : step_q;
  end

  assign elem_o = elem_q;
  assign send_o = busy_q && (elem_q != EW'(CHUNK_LEN));
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/ar_node.sv
module ar_node
  import ar_pkg::*;
#(
  parameter int NODE_ID   = 0,
  parameter int NODES     = 4,
  parameter int CHUNK_LEN = 2,
  parameter int DATA_W    = 16,
  localparam int VEC_LEN  = NODES * CHUNK_LEN,
  localparam int NW       = $clog2(NODES),
  localparam int AW       = $clog2(VEC_LEN),
  localparam int STEPS    = 2 * (NODES - 1),
  localparam int SW       = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int EW       = $clog2(CHUNK_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  ar_phase_e         phase_i,
  input  logic [SW-1:0]     step_i,
  input  logic [EW-1:0]     elem_i,
  input  logic              rx_valid_i,
  input  ar_phase_e         rx_phase_i,
  input  logic [NW-1:0]     rx_chunk_i,
  input  logic [EW-1:0]     rx_elem_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  output ar_phase_e         tx_phase_o,
  output logic [NW-1:0]     tx_chunk_o,
  output logic [EW-1:0]     tx_elem_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  function automatic logic [NW-1:0] send_chunk(input ar_phase_e ph, input logic [SW-1:0] k);
    int c;
    c = (NODE_ID + NODES + ((ph == PH_GATHER) ? 1 : 0) - int'(k)) % NODES;
    return NW'(c);
  endfunction

  function automatic logic [AW-1:0] elem_addr(input logic [NW-1:0] ch, input logic [EW-1:0] e);
    return AW'(int'(ch) * CHUNK_LEN + int'(e));
  endfunction

  logic [DATA_W-1:0] mem_q [VEC_LEN];
  logic [NW-1:0]     cur_chunk;
  logic [AW-1:0]     tx_addr, rx_addr;

  assign cur_chunk = send_chunk(phase_i, step_i);
  assign tx_addr   = elem_addr(cur_chunk, elem_i);
  assign rx_addr   = elem_addr(rx_chunk_i, rx_elem_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < VEC_LEN; i++) mem_q[i] <= '0;
      tx_valid_o <= 1'b0;
      tx_phase_o <= PH_REDUCE;
      tx_chunk_o <= '0;
      tx_elem_o  <= '0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= send_i;
      if (send_i) begin
        tx_phase_o <= phase_i;
        tx_chunk_o <= cur_chunk;
        tx_elem_o  <= elem_i;
        tx_data_o  <= mem_q[tx_addr];
      end
      if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
      if (rx_valid_i) begin
        mem_q[rx_addr] <= (rx_phase_i == PH_REDUCE) ? mem_q[rx_addr] + rx_data_i : rx_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/ring_allreduce.sv
module ring_allreduce
  import ar_pkg::*;
#(
  parameter int NODES     = 4,
  parameter int CHUNK_LEN = 2,
  parameter int DATA_W    = 16,
  localparam int VEC_LEN  = NODES * CHUNK_LEN,
  localparam int NW       = $clog2(NODES),
  localparam int AW       = $clog2(VEC_LEN),
  localparam int STEPS    = 2 * (NODES - 1),
  localparam int SW       = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int EW       = $clog2(CHUNK_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_en_i,
  input  logic [NW-1:0]     wr_node_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NW-1:0]     rd_node_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o
);

  logic          send;
  ar_phase_e     phase;
  logic [SW-1:0] step;
  logic [EW-1:0] elem;

  ar_seq #(.NODES(NODES), .CHUNK_LEN(CHUNK_LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .send_o  (send),
    .phase_o (phase),
    .step_o  (step),
    .elem_o  (elem)
  );

  logic [NODES-1:0]             tx_valid;
  ar_phase_e                    tx_phase [NODES];
  logic [NODES-1:0][NW-1:0]     tx_chunk;
  logic [NODES-1:0][EW-1:0]     tx_elem;
  logic [NODES-1:0][DATA_W-1:0] tx_data;
  logic [NODES-1:0][DATA_W-1:0] rd_all;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    localparam int PRED = (g + NODES - 1) % NODES;
    logic wr_sel;
    assign wr_sel = wr_en_i && !busy_o && (wr_node_i == NW'(g));

    ar_node #(
      .NODE_ID(g), .NODES(NODES), .CHUNK_LEN(CHUNK_LEN), .DATA_W(DATA_W)
    ) u_node (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .send_i     (send),
      .phase_i    (phase),
      .step_i     (step),
      .elem_i     (elem),
      .rx_valid_i (tx_valid[PRED]),
      .rx_phase_i (tx_phase[PRED]),
      .rx_chunk_i (tx_chunk[PRED]),
      .rx_elem_i  (tx_elem[PRED]),
      .rx_data_i  (tx_data[PRED]),
      .tx_valid_o (tx_valid[g]),
      .tx_phase_o (tx_phase[g]),
      .tx_chunk_o (tx_chunk[g]),
      .tx_elem_o  (tx_elem[g]),
      .tx_data_o  (tx_data[g]),
      .wr_en_i    (wr_sel),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .rd_addr_i  (rd_addr_i),
      .rd_data_o  (rd_all[g])
    );
  end

  assign rd_data_o = rd_all[rd_node_i];

endmodule

// File: rtl/ring_allreduce_chk.sv
module ring_allreduce_chk #(
  parameter int NODES     = 4,
  parameter int CHUNK_LEN = 2,
  localparam int TOTAL    = 2 * (NODES - 1) * (CHUNK_LEN + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o
);

  int busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= 0;
    else         busy_cnt_q <= busy_o ? busy_cnt_q + 1 : 0;
  end

  a_r4_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt_q == TOTAL));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

endmodule

bind ring_allreduce ring_allreduce_chk #(.NODES(NODES), .CHUNK_LEN(CHUNK_LEN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/ring_allreduce_test.sv
`timescale 1ns/1ps
module ring_allreduce_test;
  localparam int P   = 4;
  localparam int L   = 2;
  localparam int DW  = 16;
  localparam int V   = P * L;
  localparam int T   = 2 * (P - 1) * (L + 1);
  localparam int RED = (P - 1) * (L + 1) + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_node_i = '0;
  logic [2:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [1:0]    rd_node_i = '0;
  logic [2:0]    rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          busy_o, done_o;

  ring_allreduce #(.NODES(P), .CHUNK_LEN(L), .DATA_W(DW)) uut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit fin = 0;
  logic [DW-1:0] mdl [P][V];
  logic [DW-1:0] col [V];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int node, input int addr, output logic [DW-1:0] v);
    rd_node_i = 2'(node);
    rd_addr_i = 3'(addr);
    #0.1;
    v = rd_data_o;
  endtask

  task automatic wr(input int node, input int addr, input logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_node_i = 2'(node); wr_addr_i = 3'(addr); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    mdl[node][addr] = d;
  endtask

  task automatic load_all(input bit rnd, input logic [DW-1:0] fixed);
    for (int i = 0; i < P; i++)
      for (int j = 0; j < V; j++)
        wr(i, j, rnd ? DW'($urandom) : fixed);
  endtask

  task automatic check_all(input string tag);
    logic [DW-1:0] v;
    for (int i = 0; i < P; i++)
      for (int j = 0; j < V; j++) begin
        rd(i, j, v);
        chk(tag, 32'(v), 32'(mdl[i][j]));
      end
  endtask

  task automatic pulse_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // called at negedge n=1 of an accepted operation
  task automatic track(input bit stray, input bit chain);
    logic [DW-1:0] v;
    for (int j = 0; j < V; j++) begin
      col[j] = '0;
      for (int i = 0; i < P; i++) col[j] = col[j] + mdl[i][j];
    end
    for (int n = 1; n <= T + 2; n++) begin
      if (n > 1) @(negedge clk_i);
      start_i = 1'b0;
      wr_en_i = 1'b0;
      #0.3;
      chk((n == 1) ? "R4 busy after start" : "R5 busy window", 32'(busy_o), 32'(n <= T));
      chk((n == T + 1) ? "R5 done after busy" : "R6 done single", 32'(done_o), 32'(n == T + 1));
      if (n == RED) begin
        for (int i = 0; i < P; i++)
          for (int e = 0; e < L; e++) begin
            rd(i, ((i + 1) % P) * L + e, v);
            chk("R9 owned chunk after phase one", 32'(v), 32'(col[((i + 1) % P) * L + e]));
          end
      end
      if (stray && (n == 4 || n == T)) start_i = 1'b1;   // R8
      if (stray && n == RED + 2) begin                   // R3: owned chunk of node 0
        wr_en_i = 1'b1; wr_node_i = 2'd0; wr_addr_i = 3'(L); wr_data_i = 16'hDEAD;
      end
      if (chain && n == T + 1) begin                     // R11
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        break;
      end
    end
    for (int i = 0; i < P; i++)
      for (int j = 0; j < V; j++) mdl[i][j] = col[j];
  endtask

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < P; i++)
      for (int j = 0; j < V; j++) mdl[i][j] = '0;
    #12;
    #0.3;
    chk("R1 busy at reset", 32'(busy_o), 0);
    chk("R1 done at reset", 32'(done_o), 0);
    rst_ni = 1'b1;
    check_all("R1 zero contents");

    load_all(1'b1, '0);
    check_all("R2 readback");

    // R3, R7, R8: stray starts (incl. final busy cycle) and a write during busy
    pulse_start();
    track(1'b1, 1'b0);
    check_all("R7 R3 R8 reduced result");

    // R10: wrap-around
    load_all(1'b0, 16'hFFFF);
    pulse_start();
    track(1'b0, 1'b0);
    rd(2, 5, v);
    chk("R10 wrap value", 32'(v), 32'h0000FFFC);
    check_all("R10 wrap result");

    // R11: back-to-back start in the done cycle
    load_all(1'b1, '0);
    pulse_start();
    track(1'b0, 1'b1);
    track(1'b0, 1'b0);
    check_all("R11 chained result");

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule